// File: doc/BRIEF.md
# Carry-Save-Input Multiplier

This block multiplies an operand that is still in redundant carry-save form, given as two unsigned vectors whose sum is the value, by a binary multiplicand. The product is exact and full width. The operand is never resolved to binary on the way in. Instead, one half-adder per bit position recodes each sum/carry pair into a digit bit and a delayed-carry bit. The delayed-carry bit weighs twice the digit bit, and the two can never both be 1.

Because the two bits exclude each other, each partial-product bit is a single OR of two AND terms. The bit is either the digit times the multiplicand bit of the same column, or the delayed carry times the multiplicand bit one column lower. The partial-product rows are reduced to two vectors by a carry-save array built from full-adder and half-adder cells. A parallel-prefix adder then turns that pair into the binary product.

The block is purely combinational, with no clock or reset. It is meant to sit between two arithmetic stages where an earlier stage leaves its result in carry-save form.

Top module: `csm_mult`

## Requirements
- R1: `prod_o` equals (`sum_i` + `car_i`) * `mcand_i` as unsigned integers. The result is OP_W+MC_W+1 bits wide and is never truncated.
- R2: Bit position i of the operand is recoded into a digit bit (sum XOR carry) of weight 2^i and a delayed-carry bit (sum AND carry) of weight 2^(i+1). The recoded value equals `sum_i` + `car_i`. When every bit of both vectors is 1, all digit bits are 0 and the product is 2*(2^OP_W-1)*`mcand_i`.
- R3: In partial-product row i, column i+j is (digit_i AND mcand_j) OR (delayed-carry_i AND mcand_(j-1)), with out-of-range multiplicand bits taken as 0. The row's value equals (digit_i + 2*delayed-carry_i) * `mcand_i` * 2^i.
- R4: The carry-save array reduces all rows to two vectors whose sum, modulo 2^(OP_W+MC_W+1), equals the sum of the rows. This holds up to the maximum product (2^(OP_W+1)-2)*(2^MC_W-1).
- R5: The final prefix adder's output equals the sum of the two reduced vectors modulo 2^(OP_W+MC_W+1). This includes carries that ripple across the whole width.
- R6: If `mcand_i` is 0, or both operand vectors are 0, `prod_o` is 0.
- R7: Swapping `sum_i` and `car_i` leaves `prod_o` unchanged.
- R8: `prod_o` settles to the new result within the same clock period as an input change, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sum_i | input | OP_W | Sum vector of the carry-save operand |
| car_i | input | OP_W | Carry vector of the carry-save operand |
| mcand_i | input | MC_W | Binary multiplicand |
| prod_o | output | OP_W+MC_W+1 | Full-width binary product |

## Verification
Two things meet in the same partial-product bit: the digit term of one column and the delayed-carry term shifted up from the column below. The OR merge is correct only because the two terms exclude each other. This is provoked by operand pairs whose bits overlap in some positions and are disjoint in others, driven against dense multiplicands. The small configuration is swept exhaustively over every sum, carry and multiplicand value. Each result is judged against the product computed arithmetically in the bench. Internal checks confirm that each partial-product row, the reduced pair and the adder output each keep the arithmetic value of the stage before.

// File: rtl/csm_pkg.sv
package csm_pkg;
  function automatic int prod_width(input int op_w, input int mc_w);
    return op_w + mc_w + 1;
  endfunction

  function automatic int prefix_levels(input int w);
    int l;
    l = 0;
    while ((1 << l) < w) l++;
    return (l < 1) ? 1 : l;
  endfunction
endpackage

// File: rtl/csm_ha.sv
module csm_ha (
  input  logic a_i,
  input  logic b_i,
  output logic s_o,
  output logic c_o
);
  assign s_o = a_i ^ b_i;
  assign c_o = a_i & b_i;
endmodule

// File: rtl/csm_fa.sv
module csm_fa (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic s_o,
  output logic c_o
);
  assign s_o = a_i ^ b_i ^ c_i;
  assign c_o = (a_i & b_i) | (a_i & c_i) | (b_i & c_i);
endmodule

// File: rtl/csm_dc_recode.sv
// Turns each sum/carry pair into a digit bit and a delayed-carry bit (weight x2).
module csm_dc_recode #(
  parameter int OP_W = 8
) (
  input  logic [OP_W-1:0] sum_i,
  input  logic [OP_W-1:0] car_i,
  output logic [OP_W-1:0] dig_o,
  output logic [OP_W-1:0] ecar_o
);
  for (genvar i = 0; i < OP_W; i++) begin : g_ha
    csm_ha u_ha (
      .a_i (sum_i[i]),
      .b_i (car_i[i]),
      .s_o (dig_o[i]),
      .c_o (ecar_o[i])
    );
  end
endmodule

// File: rtl/csm_pp_gen.sv
// Merged partial products: digit and delayed carry are exclusive, so OR suffices.
module csm_pp_gen #(
  parameter int OP_W = 8,
  parameter int MC_W = 8,
  parameter int PW   = OP_W + MC_W + 1
) (
  input  logic [OP_W-1:0]    dig_i,
  input  logic [OP_W-1:0]    ecar_i,
  input  logic [MC_W-1:0]    mcand_i,
  output logic [OP_W*PW-1:0] rows_o
);
  logic [MC_W+1:0] mc_ext;
  assign mc_ext = {1'b0, mcand_i, 1'b0};

  for (genvar i = 0; i < OP_W; i++) begin : g_row
    logic [PW-1:0] row;
    always_comb begin
      row = '0;
      for (int j = 0; j <= MC_W; j++) begin
        row[i+j] = (dig_i[i] & mc_ext[j+1]) | (ecar_i[i] & mc_ext[j]);
      end
    end
    assign rows_o[i*PW +: PW] = row;
  end
endmodule

// File: rtl/csm_csa_array.sv
// Linear carry-save array: each stage absorbs one row with FA where it is live, HA elsewhere.
module csm_csa_array #(
  parameter int OP_W = 8,
  parameter int MC_W = 8,
  parameter int PW   = OP_W + MC_W + 1
) (
  input  logic [OP_W*PW-1:0] rows_i,
  output logic [PW-1:0]      tree_s_o,
  output logic [PW-1:0]      tree_c_o
);
  logic [PW-1:0] acc_s [OP_W];
  logic [PW-1:0] acc_c [OP_W];

  assign acc_s[0] = rows_i[0 +: PW];
  assign acc_c[0] = '0;

  for (genvar k = 1; k < OP_W; k++) begin : g_stage
    if (k == 1) begin : g_first
      assign acc_s[1] = acc_s[0];
      assign acc_c[1] = rows_i[PW +: PW];
    end else begin : g_cmp
      logic [PW-1:0] row_k;
      logic [PW-1:0] ns;
      logic [PW-1:0] cy;
      assign row_k = rows_i[k*PW +: PW];
      for (genvar col = 0; col < PW; col++) begin : g_col
        if (col == PW - 1) begin : g_top
          assign ns[col] = acc_s[k-1][col] ^ acc_c[k-1][col] ^ row_k[col];
          assign cy[col] = 1'b0;
        end else if (col >= k && col <= k + MC_W) begin : g_full
          csm_fa u_fa (
            .a_i (acc_s[k-1][col]),
            .b_i (acc_c[k-1][col]),
            .c_i (row_k[col]),
            .s_o (ns[col]),
            .c_o (cy[col])
          );
        end else begin : g_half
          csm_ha u_ha (
            .a_i (acc_s[k-1][col]),
            .b_i (acc_c[k-1][col]),
            .s_o (ns[col]),
            .c_o (cy[col])
          );
        end
      end
      assign acc_s[k] = ns;
      assign acc_c[k] = {cy[PW-2:0], 1'b0};
    end
  end

  assign tree_s_o = acc_s[OP_W-1];
  assign tree_c_o = acc_c[OP_W-1];
endmodule

// File: rtl/csm_prefix_add.sv
// Radix-2 minimum-depth prefix adder (unbounded fanout), generate/propagate pairs.
module csm_prefix_add #(
  parameter int W = 17
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o
);
  localparam int LV = csm_pkg::prefix_levels(W);

  logic [W-1:0] g [LV+1];
  logic [W-1:0] p [LV+1];

  assign g[0] = a_i & b_i;
  assign p[0] = a_i ^ b_i;

  for (genvar l = 0; l < LV; l++) begin : g_lvl
    for (genvar i = 0; i < W; i++) begin : g_bit
      if (((i >> l) & 1) == 1) begin : g_node
        localparam int J = ((i >> l) << l) - 1;
        assign g[l+1][i] = g[l][i] | (p[l][i] & g[l][J]);
        assign p[l+1][i] = p[l][i] & p[l][J];
      end else begin : g_pass
        assign g[l+1][i] = g[l][i];
        assign p[l+1][i] = p[l][i];
      end
    end
  end

  assign sum_o[0] = p[0][0];
  for (genvar i = 1; i < W; i++) begin : g_sum
    assign sum_o[i] = p[0][i] ^ g[LV][i-1];
  end
endmodule

// File: rtl/csm_mult.sv
module csm_mult #(
  parameter int OP_W = 8,
  parameter int MC_W = 8
) (
  input  logic [OP_W-1:0]      sum_i,
  input  logic [OP_W-1:0]      car_i,
  input  logic [MC_W-1:0]      mcand_i,
  output logic [OP_W+MC_W:0]   prod_o
);
  localparam int PW = csm_pkg::prod_width(OP_W, MC_W);

  logic [OP_W-1:0]    dig_w;
  logic [OP_W-1:0]    ecar_w;
  logic [OP_W*PW-1:0] pp_rows;
  logic [PW-1:0]      tree_s;
  logic [PW-1:0]      tree_c;

  csm_dc_recode #(.OP_W(OP_W)) u_rec (
    .sum_i  (sum_i),
    .car_i  (car_i),
    .dig_o  (dig_w),
    .ecar_o (ecar_w)
  );

  csm_pp_gen #(.OP_W(OP_W), .MC_W(MC_W), .PW(PW)) u_pp (
    .dig_i   (dig_w),
    .ecar_i  (ecar_w),
    .mcand_i (mcand_i),
    .rows_o  (pp_rows)
  );

  csm_csa_array #(.OP_W(OP_W), .MC_W(MC_W), .PW(PW)) u_csa (
    .rows_i   (pp_rows),
    .tree_s_o (tree_s),
    .tree_c_o (tree_c)
  );

  csm_prefix_add #(.W(PW)) u_cpa (
    .a_i   (tree_s),
    .b_i   (tree_c),
    .sum_o (prod_o)
  );
endmodule

// File: rtl/csm_mult_chk.sv
module csm_mult_chk #(
  parameter int OP_W = 8,
  parameter int MC_W = 8
) (
  input logic [OP_W-1:0]                 sum_i,
  input logic [OP_W-1:0]                 car_i,
  input logic [MC_W-1:0]                 mcand_i,
  input logic [OP_W-1:0]                 dig_i,
  input logic [OP_W-1:0]                 ecar_i,
  input logic [OP_W*(OP_W+MC_W+1)-1:0]   rows_i,
  input logic [OP_W+MC_W:0]              tree_s_i,
  input logic [OP_W+MC_W:0]              tree_c_i,
  input logic [OP_W+MC_W:0]              prod_i
);
  localparam int PW = OP_W + MC_W + 1;

  logic [PW-1:0] opnd;
  logic [PW-1:0] mcx;
  logic [PW-1:0] row_sum;
  logic [PW-1:0] row_exp;

  assign opnd = PW'(sum_i) + PW'(car_i);
  assign mcx  = PW'(mcand_i);

  always_comb begin
    assert_product_R1: assert (prod_i == opnd * mcx)
      else $error("R1 product mismatch");
    assert_recode_R2: assert ((PW'(dig_i) + (PW'(ecar_i) << 1)) == opnd)
      else $error("R2 recoded value mismatch");
    row_sum = '0;
    for (int i = 0; i < OP_W; i++) begin
      row_exp = ((dig_i[i] ? mcx : '0) << i) + ((ecar_i[i] ? mcx : '0) << (i + 1));
      assert_row_R3: assert (rows_i[i*PW +: PW] == row_exp)
        else $error("R3 partial-product row mismatch");
      row_sum = row_sum + rows_i[i*PW +: PW];
    end
    assert_tree_R4: assert (PW'(tree_s_i + tree_c_i) == row_sum)
      else $error("R4 reduced pair mismatch");
    assert_cpa_R5: assert (prod_i == PW'(tree_s_i + tree_c_i))
      else $error("R5 final adder mismatch");
    if (mcand_i == '0 || (sum_i == '0 && car_i == '0)) begin
      assert_zero_R6: assert (prod_i == '0)
        else $error("R6 zero product violated");
    end
  end
endmodule

bind csm_mult csm_mult_chk #(.OP_W(OP_W), .MC_W(MC_W)) u_chk (
  .sum_i    (sum_i),
  .car_i    (car_i),
  .mcand_i  (mcand_i),
  .dig_i    (dig_w),
  .ecar_i   (ecar_w),
  .rows_i   (pp_rows),
  .tree_s_i (tree_s),
  .tree_c_i (tree_c),
  .prod_i   (prod_o)
);

// File: tb/csm_mult_tb.sv
`timescale 1ns/1ps
module csm_mult_tb_top;
  localparam int BN = 8;
  localparam int BM = 8;
  localparam int SN = 3;
  localparam int SM = 3;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [BN-1:0]    s_b, c_b;
  logic [BM-1:0]    m_b;
  logic [BN+BM:0]   p_b;
  logic [SN-1:0]    s_s, c_s;
  logic [SM-1:0]    m_s;
  logic [SN+SM:0]   p_s;

  csm_mult #(.OP_W(BN), .MC_W(BM)) dut_i (
    .sum_i (s_b), .car_i (c_b), .mcand_i (m_b), .prod_o (p_b)
  );

  csm_mult #(.OP_W(SN), .MC_W(SM)) dut_sm_i (
    .sum_i (s_s), .car_i (c_s), .mcand_i (m_s), .prod_o (p_s)
  );

  task automatic chk(input longint act, input longint exp, input string req);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic longint ref_b(input logic [BN-1:0] s, input logic [BN-1:0] c,
                                   input logic [BM-1:0] m);
    return (longint'(s) + longint'(c)) * longint'(m);
  endfunction

  task automatic big(input logic [BN-1:0] s, input logic [BN-1:0] c,
                     input logic [BM-1:0] m, input string req);
    @(posedge clk);
    #1;
    s_b = s; c_b = c; m_b = m;
    @(negedge clk);
    chk(longint'(p_b), ref_b(s, c, m), req);
  endtask

  initial begin
    s_b = '0; c_b = '0; m_b = '0;
    s_s = '0; c_s = '0; m_s = '0;
    @(negedge clk);
    chk(longint'(p_b), 0, "R6 idle zero");
    chk(longint'(p_s), 0, "R6 idle zero small");

    // exhaustive small configuration
    for (int s = 0; s < (1 << SN); s++) begin
      for (int c = 0; c < (1 << SN); c++) begin
        for (int m = 0; m < (1 << SM); m++) begin
          @(posedge clk);
          #1;
          s_s = SN'(s); c_s = SN'(c); m_s = SM'(m);
          @(negedge clk);
          chk(longint'(p_s), longint'((s + c) * m), "R1 exhaustive");
        end
      end
    end

    big('1, '1, '1, "R4 maximum product");
    chk(longint'(p_b[BN+BM]), 1, "R1 top bit used");
    big('1, '1, 8'h5b, "R2 all delayed carries");
    big(8'hb4, 8'h4b, 8'hff, "R3 disjoint vectors all digits");
    big(8'hcc, 8'h6a, 8'hff, "R3 mixed overlap dense multiplicand");
    big(8'h01, 8'hff, 8'hff, "R5 long carry chain");
    big(8'h80, 8'h80, 8'h80, "R2 top-bit delayed carry");
    big(8'h00, 8'h00, 8'hff, "R6 zero operand");
    big(8'h9f, 8'h31, 8'h00, "R6 zero multiplicand");

    for (int k = 0; k < 300; k++) begin
      logic [BN-1:0] rs, rc;
      logic [BM-1:0] rm;
      longint first;
      rs = BN'($urandom); rc = BN'($urandom); rm = BM'($urandom);
      big(rs, rc, rm, "R1 random");
      first = longint'(p_b);
      big(rc, rs, rm, "R7 swapped vectors");
      chk(longint'(p_b), first, "R7 swap equal");
    end

    // no clock edge between input change and sampling
    @(negedge clk);
    #0.5;
    s_b = 8'h3c; c_b = 8'h77; m_b = 8'he1;
    #0.5;
    chk(longint'(p_b), ref_b(8'h3c, 8'h77, 8'he1), "R8 settles without edge");
    s_b = 8'hff; c_b = 8'h01; m_b = 8'h81;
    #0.5;
    chk(longint'(p_b), ref_b(8'hff, 8'h01, 8'h81), "R8 second change same period");

    for (int k = 0; k < 2000; k++) begin
      big(BN'($urandom), BN'($urandom), BM'($urandom), "R1 random sweep");
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule